// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block times an external pulse in units of a count-source tick. A free-running counter advances on every clock cycle in which the tick enable is high, while the start input is high. On each qualifying edge of the synchronized measurement input, the block does three things in the same cycle. It copies the current count into a capture register, clears the counter to zero and raises the interrupt request.

In period mode, only falling edges qualify, so each capture is the time from one falling edge to the next. In width mode, every edge qualifies, so captures alternate between the low time and the high time of the pulse. The first capture after start goes high covers no complete interval and is marked not valid. A counter wrap sets a sticky overflow flag, which is cleared only by a control-register write made while the timer runs.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset, the control/status register, the capture register, the counter and the interrupt flag all read zero, and `irq` is low.
- R2: While `start` is high and no capture occurs, the counter grows by exactly one on each clock cycle with `tick_en` high and holds on cycles with `tick_en` low.
- R3: While `start` is low, the counter is held at zero. Edges cause no capture and no interrupt, and the capture register keeps its value.
- R4: Mode 00 (period) captures on falling edges only. The captured value is the number of ticks since the previous capture, and the counter restarts from zero. With `tick_en` held high, an interval of N clock cycles captures N-1.
- R5: Mode 10 (width) captures on both edges. A capture at a rising edge holds the low time, and a capture at a falling edge holds the high time, each in ticks.
- R6: Modes 01 and 11 behave exactly as mode 00.
- R7: Status bit 3 (capture valid) is 0 after the first capture following a rise of `start`, and 1 after every later capture.
- R8: When the counter wraps from all-ones to zero on a tick, status bit 2 (overflow) and the interrupt flag are set.
- R9: The overflow flag survives captures and control writes made while `start` is low. It is cleared by a control write made while `start` is high.
- R10: The interrupt flag (`irq`, interrupt register bit 0) is set by a capture or a wrap. It is cleared by `irq_ack` or by a write of 0 to bit 0 of the interrupt register. Writing 1 has no effect, and a set in the same cycle wins over a clear.
- R11: Register map, with reads combinational:
  - Address 0 is control/status. Bits 1:0 are the mode (read/write), bit 2 is overflow and bit 3 is valid.
  - Address 1 is the capture register.
  - Address 2 is the interrupt flag.
  - Address 3 is the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-source enable, one cycle per tick |
| meas_in | input | 1 | Pulse to be measured (asynchronous) |
| start | input | 1 | Run enable for the counter |
| irq_ack | input | 1 | Interrupt accepted, clears the flag |
| reg_sel | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_sel` |
| irq | output | 1 | Interrupt request |

## Verification
Both period and width mode are swept over every combination of low time and high time from 1 to 12 cycles. In period mode the final capture must equal the sum minus one, while in width mode it must equal only the high time minus one. A reading taken after the rising edge shows whether that edge captured the low time or left the first, invalid capture untouched. The two reserved modes repeat the period sweep to show that they match mode 00. Runs with the tick enable low, with `start` low, and a run long enough to wrap the counter separate tick gating, stopping and the overflow clearing rule.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    MODE_PERIOD = 2'b00,
    MODE_RSV1   = 2'b01,
    MODE_WIDTH  = 2'b10,
    MODE_RSV3   = 2'b11
  } meas_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CAPT = 2'd1;
  localparam logic [1:0] ADDR_IRQ  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int STAT_OVF_BIT   = 2;
  localparam int STAT_VALID_BIT = 3;
endpackage

// File: rtl/pmt_edge_sync.sv
module pmt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], din};
    prev_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[TOP] & ~prev_q;
  assign fall = ~sync_q[TOP] & prev_q;
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             irq_ack,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output meas_mode_e       mode,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             ovf,
  output logic             irq,
  output logic [CNT_W-1:0] cap
);
  meas_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             valid_q, valid_d;
  logic             first_q, first_d;
  logic             ovf_q, ovf_d;
  logic             irq_q, irq_d;
  logic             ctrl_wr, irq_clr_wr;

  always_comb begin
    ctrl_wr    = reg_wr && (reg_sel == ADDR_CTRL);
    irq_clr_wr = reg_wr && (reg_sel == ADDR_IRQ) && !reg_wdata[0];

    mode_d  = ctrl_wr ? meas_mode_e'(reg_wdata[1:0]) : mode_q;
    cap_d   = cap_q;
    valid_d = valid_q;
    if (cap_evt) begin
      cap_d   = cnt;
      valid_d = !first_q;
    end

    if (!run)         first_d = 1'b1;
    else if (cap_evt) first_d = 1'b0;
    else              first_d = first_q;

    if (wrap)                 ovf_d = 1'b1;
    else if (ctrl_wr && run)  ovf_d = 1'b0;
    else                      ovf_d = ovf_q;

    if (cap_evt || wrap)            irq_d = 1'b1;
    else if (irq_ack || irq_clr_wr) irq_d = 1'b0;
    else                            irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PERIOD;
      cap_q   <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b1;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      cap_q   <= cap_d;
      valid_q <= valid_d;
      first_q <= first_d;
      ovf_q   <= ovf_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      ADDR_CTRL: begin
        reg_rdata[1:0]            = mode_q;
        reg_rdata[STAT_OVF_BIT]   = ovf_q;
        reg_rdata[STAT_VALID_BIT] = valid_q;
      end
      ADDR_CAPT: reg_rdata    = cap_q;
      ADDR_IRQ:  reg_rdata[0] = irq_q;
      default:   reg_rdata    = cnt;
    endcase
  end

  assign mode = mode_q;
  assign ovf  = ovf_q;
  assign irq  = irq_q;
  assign cap  = cap_q;
endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             meas_in,
  input  logic             start,
  input  logic             irq_ack,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic             rst_meta_q, rst_q;
  logic             edge_rise, edge_fall;
  logic             cap_evt, wrap;
  logic [CNT_W-1:0] cnt, cap;
  logic             ovf;
  meas_mode_e       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  pmt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_q),
    .din  (meas_in),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  assign cap_evt = start & (edge_fall | ((mode == MODE_WIDTH) & edge_rise));

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_q),
    .run  (start),
    .tick (tick_en),
    .clear(cap_evt),
    .cnt  (cnt),
    .wrap (wrap)
  );

  pmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .run      (start),
    .cap_evt  (cap_evt),
    .cnt      (cnt),
    .wrap     (wrap),
    .irq_ack  (irq_ack),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .mode     (mode),
    .reg_rdata(reg_rdata),
    .ovf      (ovf),
    .irq      (irq),
    .cap      (cap)
  );
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             tick_en,
  input logic             cap_evt,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap,
  input logic             ovf,
  input logic             irq,
  input logic             irq_ack,
  input logic             reg_wr,
  input logic [1:0]       reg_sel
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tick_en && !cap_evt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tick_en && !cap_evt) |=> $stable(cnt));

  assert_stopped_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt == '0 && $stable(cap)));

  assert_capture_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap == $past(cnt) && cnt == '0));

  assert_wrap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf && irq));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && reg_sel == 2'd0 && start)) |=> ovf);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cap_evt || wrap));

  assert_irq_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cap_evt && !wrap) |=> !irq);
endmodule

bind pulse_meas_timer pmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_q),
  .start  (start),
  .tick_en(tick_en),
  .cap_evt(cap_evt),
  .wrap   (wrap),
  .cnt    (cnt),
  .cap    (cap),
  .ovf    (ovf),
  .irq    (irq),
  .irq_ack(irq_ack),
  .reg_wr (reg_wr),
  .reg_sel(reg_sel)
);

// File: tb/pulse_meas_timer_test.sv
`timescale 1ns/1ps
module pulse_meas_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, tick_en, meas_in, start, irq_ack, reg_wr;
  logic [1:0]   reg_sel;
  logic [W-1:0] reg_wdata, reg_rdata;
  logic         irq;
  int           n_checks = 0;
  int           n_fail   = 0;

  always #5 clk = ~clk;

  pulse_meas_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .meas_in(meas_in),
    .start(start), .irq_ack(irq_ack), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] val);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    reg_sel   = sel;
    reg_wdata = data;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // Falling edge (first, invalid capture), low for a cycles, high for b cycles, falling edge.
  task automatic run_seq(input logic [1:0] m, input int a, input int b, input logic ticking);
    logic [W-1:0] v;
    logic         wid;
    int           exp_final;
    wid       = (m == 2'b10);
    exp_final = !ticking ? 0 : (wid ? b - 1 : a + b - 1);
    start   = 1'b0;
    meas_in = 1'b1;
    wr(2'd0, W'(m));
    wait_n(4);
    start = 1'b1;
    wait_n(2);
    meas_in = 1'b0;
    wait_n(a);
    meas_in = 1'b1;
    if (b >= 6) begin
      wait_n(5);
      rd(2'd0, v);
      check(wid ? "R5 valid after rise" : "R7 no capture on rise", W'(v[3]), W'(wid));
      if (wid) begin
        rd(2'd1, v);
        check("R5 low time", v, ticking ? W'(a - 1) : W'(0));
      end
      wait_n(b - 5);
    end else begin
      wait_n(b);
    end
    meas_in = 1'b0;
    wait_n(6);
    rd(2'd1, v);
    check(wid ? "R5 high time" : (m == 2'b00 ? "R4 period" : "R6 reserved mode"), v, W'(exp_final));
    rd(2'd0, v);
    check("R7 valid", W'(v[3]), W'(1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v, c0;
    rst_n = 1'b0; tick_en = 1'b0; meas_in = 1'b1; start = 1'b0;
    irq_ack = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, '0);
    end
    check("R1 irq pin", W'(irq), '0);

    tick_en = 1'b1;
    wait_n(5);
    rd(2'd3, v);
    check("R3 count held while stopped", v, '0);
    start = 1'b1;
    wait_n(10);
    rd(2'd3, v);
    check("R2 count per tick", v, W'(10));
    tick_en = 1'b0;
    wait_n(5);
    rd(2'd3, v);
    check("R2 count holds without tick", v, W'(10));
    tick_en = 1'b1;

    for (int a = 1; a <= 12; a++)
      for (int b = 1; b <= 12; b++) begin
        run_seq(2'b00, a, b, 1'b1);
        run_seq(2'b10, a, b, 1'b1);
      end
    for (int a = 1; a <= 12; a++) begin
      run_seq(2'b01, a, 7, 1'b1);
      run_seq(2'b11, a, 7, 1'b1);
    end

    tick_en = 1'b0;
    run_seq(2'b00, 5, 6, 1'b0);
    run_seq(2'b10, 7, 8, 1'b0);
    tick_en = 1'b1;

    check("R10 irq set by capture", W'(irq), W'(1));
    irq_ack = 1'b1;
    wait_n(1);
    irq_ack = 1'b0;
    check("R10 irq cleared by ack", W'(irq), '0);
    run_seq(2'b00, 3, 4, 1'b1);
    wr(2'd2, W'(1));
    check("R10 write 1 keeps irq", W'(irq), W'(1));
    wr(2'd2, W'(0));
    check("R10 write 0 clears irq", W'(irq), '0);

    rd(2'd1, c0);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      meas_in = ~meas_in;
      wait_n(5);
    end
    rd(2'd1, v);
    check("R3 capture kept while stopped", v, c0);
    check("R3 no irq while stopped", W'(irq), '0);
    rd(2'd3, v);
    check("R3 counter zero while stopped", v, '0);

    start = 1'b0;
    meas_in = 1'b1;
    wr(2'd0, W'(0));
    wait_n(4);
    start = 1'b1;
    wait_n(65540);
    rd(2'd0, v);
    check("R8 overflow flag", W'(v[2]), W'(1));
    check("R8 irq on wrap", W'(irq), W'(1));
    meas_in = 1'b0;
    wait_n(6);
    rd(2'd0, v);
    check("R9 capture keeps overflow", W'(v[2]), W'(1));
    start = 1'b0;
    wr(2'd0, W'(0));
    rd(2'd0, v);
    check("R9 stopped write keeps overflow", W'(v[2]), W'(1));
    start = 1'b1;
    wr(2'd0, W'(0));
    rd(2'd0, v);
    check("R9 running write clears overflow", W'(v[2]), '0);
    wr(2'd0, W'(2));
    rd(2'd0, v);
    check("R11 mode field readback", W'(v[1:0]), W'(2));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule